// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block serves the transmit side of a network controller. Software lays out a ring of eight-byte buffer descriptors in memory, programs the ring's start address, sets the controller enable and then pulses a demand strobe. The walker starts at its current descriptor pointer. It fetches each descriptor over a single-outstanding memory request/response port, then reads the referenced buffer one 32-bit word at a time. It streams the bytes in buffer order on a byte stream that has a last marker and a byte-keep qualifier. Each descriptor it consumes is written back with its ready flag cleared.

Several fragments are gathered into one frame until a descriptor with the last flag arrives. A frame never grows past a fixed maximum length. Any excess is dropped and a babble event is pulsed. One demand stops at the first descriptor that is not ready, or after a fixed number of descriptors. The pointer is left where the walk stopped, so the next demand continues from there.

Top module: `tx_ring_engine`

## Requirements
- R1: A demand pulse starts a walk only while `ctrl_enable` is high and the engine is idle. A demand while disabled causes no memory request, and `demand_busy` stays 0. `demand_busy` is 1 during a walk and returns to 0 when the walk ends.
- R2: A walk ends at the first descriptor whose ready flag is clear. Only the first word of that descriptor is read: nothing is streamed, nothing is written back, and no event is raised. The next demand starts at that same descriptor.
- R3: Descriptor word 0, at the pointer, holds the flags in bits 31:16 and the byte length in bits 15:0. The flags are ready at bit 31, wrap at bit 29 and last at bit 27. Word 1, at pointer+4, holds the buffer's byte address. Buffer bytes are taken little-endian from 32-bit words, and the buffer may start at any byte offset.
- R4: Buffer bytes go out with `out_keep`=1 in address order, and the fragments of successive descriptors are concatenated. `out_last` is set on the final byte of a descriptor that has the last flag.
- R5: If the frame's accumulated length plus a descriptor's length exceeds MAX_FRAME, only the bytes up to MAX_FRAME are sent. That descriptor's write-back then also pulses `ev_babble`.
- R6: If a last descriptor contributes zero bytes, one beat with `out_keep`=0 and `out_last`=1 closes the frame.
- R7: Every consumed descriptor has word 0 written back with bit 31 cleared and all other bits unchanged. One cycle later, `ev_txbuf` pulses. `ev_txframe` pulses alongside it when the descriptor had the last flag.
- R8: After a descriptor with the wrap flag, the next pointer is the ring start. Otherwise the next pointer is the current pointer + 8.
- R9: One demand consumes at most WALK_LIMIT descriptors. The next demand resumes at the first descriptor that was not consumed.
- R10: While the engine is idle and `ctrl_enable` is low, the pointer is reloaded from the ring start. The ring start ignores bits 1:0 of the written value.
- R11: A memory request holds its address, direction and data until `mem_ack`. A stream beat holds until `out_ready`.
- R12: After reset, no request or beat is issued, `demand_busy` is 0, and the pointer and ring start are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_enable | input | 1 | Controller enable level |
| ring_base_wr | input | 1 | Write strobe for the ring start |
| ring_base_data | input | 32 | Ring start byte address |
| demand | input | 1 | Transmit demand pulse |
| demand_busy | output | 1 | Walk in progress (demand readback) |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completes this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| out_valid | output | 1 | Stream beat valid |
| out_data | output | 8 | Stream byte |
| out_keep | output | 1 | Beat carries a byte |
| out_last | output | 1 | Beat closes the frame |
| out_ready | input | 1 | Stream sink accepts the beat |
| ev_txbuf | output | 1 | Descriptor consumed pulse |
| ev_txframe | output | 1 | Frame completed pulse |
| ev_babble | output | 1 | Frame length cap hit pulse |

## Verification
The hardest case to reach is a last descriptor that arrives after the frame has already hit the length cap. Only that case produces the keep-less closing beat together with a second babble event. The stimulus builds it by sending an oversized first fragment and then a small last fragment into a deliberately short cap. The walk limit and the ring-start reload are reached the same way, through a small limit and a ring whose descriptors are all ready. The pointer is then observed through the address of the next demand's first read.

// File: rtl/txr_pkg.sv
// Shared definitions for the transmit descriptor ring walker.
// Assumes 32-bit memory words and an eight-byte descriptor.
package txr_pkg;
    localparam int WORD_W     = 32;
    localparam int FLAG_READY = 15;
    localparam int FLAG_WRAP  = 13;
    localparam int FLAG_LAST  = 11;
    localparam int DESC_BYTES = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEAD,
        ST_PTR,
        ST_FETCH,
        ST_EMIT,
        ST_MARK,
        ST_BACK
    } txr_state_t;
endpackage

// File: rtl/txr_ptr.sv
// Holds the ring start register and the current descriptor pointer.
// Assumes reload and advance never assert together.
module txr_ptr #(
    parameter int AW   = 32,
    parameter int STEP = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          base_wr,
    input  logic [AW-1:0] base_in,
    input  logic          reload,
    input  logic          advance,
    input  logic          wrap,
    output logic [AW-1:0] cur
);
    localparam logic [AW-1:0] STEP_V = AW'(STEP);
    localparam logic [AW-1:0] LOW_MASK = AW'(3);

    logic [AW-1:0] base_q;

    // Ring start register; the two lowest address bits are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n)
            base_q <= '0;
        else if (base_wr)
            base_q <= base_in & ~LOW_MASK;
    end

    // Descriptor pointer: reload from ring start, or step and wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur <= '0;
        else if (reload)
            cur <= base_q;
        else if (advance)
            cur <= wrap ? base_q : cur + STEP_V;
    end
endmodule

// File: rtl/txr_clamp.sv
// Limits a fragment so the frame length never exceeds MAX_FRAME.
// Assumes used <= MAX_FRAME < 2**LEN_W.
module txr_clamp #(
    parameter int LEN_W     = 16,
    parameter int MAX_FRAME = 1518
) (
    input  logic [LEN_W-1:0] used,
    input  logic [LEN_W-1:0] want,
    output logic [LEN_W-1:0] take,
    output logic             over
);
    localparam logic [LEN_W-1:0] MAXV = LEN_W'(MAX_FRAME);

    logic [LEN_W-1:0] room;

    // Remaining room in the frame and the clipped fragment size.
    always_comb begin
        room = MAXV - used;
        over = want > room;
        take = over ? room : want;
    end
endmodule

// File: rtl/txr_lane.sv
// Selects one byte lane of a little-endian memory word.
// Assumes a 32-bit word.
module txr_lane (
    input  logic [31:0] word,
    input  logic [1:0]  sel,
    output logic [7:0]  byte_out
);
    logic [7:0] lanes [4];

    for (genvar g = 0; g < 4; g++) begin : g_lane
        assign lanes[g] = word[g*8 +: 8];
    end

    // Lane multiplexer.
    always_comb byte_out = lanes[sel];
endmodule

// File: rtl/tx_ring_engine.sv
// Walks a transmit descriptor ring on demand and streams the gathered frame bytes.
// Assumes a memory port with one request outstanding, completed by a
// one-cycle mem_ack, and descriptors laid out as in txr_pkg.
module tx_ring_engine
    import txr_pkg::*;
#(
    parameter int LEN_W      = 16,
    parameter int MAX_FRAME  = 1518,
    parameter int WALK_LIMIT = 1024
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctrl_enable,
    input  logic        ring_base_wr,
    input  logic [31:0] ring_base_data,
    input  logic        demand,
    output logic        demand_busy,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    output logic        out_valid,
    output logic [7:0]  out_data,
    output logic        out_keep,
    output logic        out_last,
    input  logic        out_ready,
    output logic        ev_txbuf,
    output logic        ev_txframe,
    output logic        ev_babble
);
    localparam int WALK_W = $clog2(WALK_LIMIT + 1);
    localparam logic [WALK_W-1:0] WALK_END = WALK_W'(WALK_LIMIT - 1);
    localparam logic [15:0] READY_MASK = 16'(1) << FLAG_READY;
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    txr_state_t        state;
    logic [15:0]       flags_q;
    logic [15:0]       blen_q;
    logic [31:0]       bptr_q;
    logic [31:0]       word_q;
    logic [LEN_W-1:0]  remain_q;
    logic [LEN_W-1:0]  used_q;
    logic              trunc_q;
    logic [WALK_W-1:0] walk_q;
    logic [31:0]       cur;
    logic [LEN_W-1:0]  take;
    logic              over;
    logic [7:0]        lane_byte;
    logic              advance;
    logic              reload;
    logic              is_last;

    assign is_last = flags_q[FLAG_LAST];
    assign advance = (state == ST_BACK) && mem_ack;
    assign reload  = (state == ST_IDLE) && !ctrl_enable;

    txr_ptr #(.AW(32), .STEP(DESC_BYTES)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .base_wr (ring_base_wr),
        .base_in (ring_base_data),
        .reload  (reload),
        .advance (advance),
        .wrap    (flags_q[FLAG_WRAP]),
        .cur     (cur)
    );

    txr_clamp #(.LEN_W(LEN_W), .MAX_FRAME(MAX_FRAME)) u_clamp (
        .used (used_q),
        .want (LEN_W'(blen_q)),
        .take (take),
        .over (over)
    );

    txr_lane u_lane (
        .word     (word_q),
        .sel      (bptr_q[1:0]),
        .byte_out (lane_byte)
    );

    // Memory request fields decoded from the walk state.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state)
            ST_HEAD:  begin mem_req = 1'b1; mem_addr = cur; end
            ST_PTR:   begin mem_req = 1'b1; mem_addr = cur + 32'd4; end
            ST_FETCH: begin mem_req = 1'b1; mem_addr = {bptr_q[31:2], 2'b00}; end
            ST_BACK:  begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur;
                mem_wdata = {flags_q & ~READY_MASK, blen_q};
            end
            default: ;
        endcase
    end

    // Stream beat fields decoded from the walk state.
    always_comb begin
        out_valid   = (state == ST_EMIT) || (state == ST_MARK);
        out_keep    = (state == ST_EMIT);
        out_data    = (state == ST_EMIT) ? lane_byte : 8'h00;
        out_last    = (state == ST_MARK) ||
                      ((state == ST_EMIT) && is_last && (remain_q == ONE));
        demand_busy = (state != ST_IDLE);
    end

    // Walk sequencer: fetch, gather, stream, write back, advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            flags_q    <= '0;
            blen_q     <= '0;
            bptr_q     <= '0;
            word_q     <= '0;
            remain_q   <= '0;
            used_q     <= '0;
            trunc_q    <= 1'b0;
            walk_q     <= '0;
            ev_txbuf   <= 1'b0;
            ev_txframe <= 1'b0;
            ev_babble  <= 1'b0;
        end else begin
            ev_txbuf   <= 1'b0;
            ev_txframe <= 1'b0;
            ev_babble  <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (demand && ctrl_enable) begin
                        used_q <= '0;
                        walk_q <= '0;
                        state  <= ST_HEAD;
                    end
                end
                ST_HEAD: begin
                    if (mem_ack) begin
                        flags_q <= mem_rdata[31:16];
                        blen_q  <= mem_rdata[15:0];
                        state   <= mem_rdata[16 + FLAG_READY] ? ST_PTR : ST_IDLE;
                    end
                end
                ST_PTR: begin
                    if (mem_ack) begin
                        bptr_q   <= mem_rdata;
                        remain_q <= take;
                        used_q   <= used_q + take;
                        trunc_q  <= over;
                        if (take != '0)
                            state <= ST_FETCH;
                        else
                            state <= is_last ? ST_MARK : ST_BACK;
                    end
                end
                ST_FETCH: begin
                    if (mem_ack) begin
                        word_q <= mem_rdata;
                        state  <= ST_EMIT;
                    end
                end
                ST_EMIT: begin
                    if (out_ready) begin
                        bptr_q   <= bptr_q + 32'd1;
                        remain_q <= remain_q - ONE;
                        if (remain_q == ONE)
                            state <= ST_BACK;
                        else if (bptr_q[1:0] == 2'b11)
                            state <= ST_FETCH;
                    end
                end
                ST_MARK: begin
                    if (out_ready)
                        state <= ST_BACK;
                end
                ST_BACK: begin
                    if (mem_ack) begin
                        ev_txbuf   <= 1'b1;
                        ev_txframe <= is_last;
                        ev_babble  <= trunc_q;
                        if (is_last)
                            used_q <= '0;
                        walk_q <= walk_q + 1'b1;
                        state  <= (walk_q == WALK_END) ? ST_IDLE : ST_HEAD;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/txr_check.sv
// Protocol and rule checks for the transmit ring walker, bound to its ports.
module txr_check #(
    parameter int MAX_FRAME = 1518
) (
    input logic        clk,
    input logic        rst_n,
    input logic        ctrl_enable,
    input logic        demand,
    input logic        demand_busy,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        mem_ack,
    input logic        out_valid,
    input logic [7:0]  out_data,
    input logic        out_keep,
    input logic        out_last,
    input logic        out_ready,
    input logic        ev_txbuf,
    input logic        ev_txframe,
    input logic        ev_babble
);
    logic [31:0] fbytes;

    // Count kept bytes of the current frame.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fbytes <= '0;
        else if (out_valid && out_ready && out_last)
            fbytes <= '0;
        else if (out_valid && out_ready && out_keep)
            fbytes <= fbytes + 32'd1;
    end

    assert_disabled_demand_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!demand_busy && demand && !ctrl_enable) |=> !demand_busy);

    assert_frame_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_keep) |-> (fbytes < 32'(MAX_FRAME)));

    assert_empty_beat_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_keep) |-> out_last);

    assert_writeback_clears_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> !mem_wdata[31]);

    assert_frame_event_with_buf_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ev_txframe |-> ev_txbuf);

    assert_babble_with_buf_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_babble |-> ev_txbuf);

    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata)));

    assert_beat_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                       && $stable(out_keep) && $stable(out_last)));

    assert_beat_only_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid || mem_req) |-> demand_busy);
endmodule

bind tx_ring_engine txr_check #(.MAX_FRAME(MAX_FRAME)) u_txr_check (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_enable (ctrl_enable),
    .demand      (demand),
    .demand_busy (demand_busy),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_ack     (mem_ack),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .out_keep    (out_keep),
    .out_last    (out_last),
    .out_ready   (out_ready),
    .ev_txbuf    (ev_txbuf),
    .ev_txframe  (ev_txframe),
    .ev_babble   (ev_babble)
);

// File: tb/tx_ring_engine_test.sv
module tx_ring_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam int MAXF = 20;
    localparam int WLIM = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_enable = 1'b0;
    logic        ring_base_wr = 1'b0;
    logic [31:0] ring_base_data = '0;
    logic        demand = 1'b0;
    logic        demand_busy;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        out_valid, out_keep, out_last;
    logic [7:0]  out_data;
    logic        out_ready = 1'b1;
    logic        ev_txbuf, ev_txframe, ev_babble;

    always #(CLK_PERIOD/2) clk = ~clk;

    tx_ring_engine #(.LEN_W(16), .MAX_FRAME(MAXF), .WALK_LIMIT(WLIM)) uut (
        .clk(clk), .rst_n(rst_n), .ctrl_enable(ctrl_enable),
        .ring_base_wr(ring_base_wr), .ring_base_data(ring_base_data),
        .demand(demand), .demand_busy(demand_busy),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .out_valid(out_valid), .out_data(out_data), .out_keep(out_keep),
        .out_last(out_last), .out_ready(out_ready),
        .ev_txbuf(ev_txbuf), .ev_txframe(ev_txframe), .ev_babble(ev_babble)
    );

    int n_chk = 0;
    int n_bad = 0;

    typedef struct packed { logic keep; logic last; logic [7:0] data; } beat_t;
    beat_t exp_q[$];

    logic [31:0] mem [0:511];
    int cnt_buf = 0, cnt_frame = 0, cnt_bab = 0, cnt_req = 0;
    int rdy_cnt = 0;
    logic cap_first = 1'b0;
    logic [31:0] first_addr = '0;

    function automatic logic [7:0] pat(input int a);
        return 8'(a * 7 + 3);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Memory responder: one-cycle acknowledge, writes land on acceptance.
    always @(posedge clk) begin
        mem_ack <= 1'b0;
        if (mem_req && !mem_ack) begin
            mem_ack   <= 1'b1;
            mem_rdata <= mem[mem_addr[10:2]];
            if (mem_we) mem[mem_addr[10:2]] <= mem_wdata;
        end
    end

    // Monitor: sink back-pressure, scoreboard compare, event and request counts.
    always @(negedge clk) begin
        rdy_cnt++;
        out_ready = (rdy_cnt % 5) != 2;
        if (rst_n) begin
            if (ev_txbuf) cnt_buf++;
            if (ev_txframe) cnt_frame++;
            if (ev_babble) cnt_bab++;
            if (mem_req && !mem_ack) cnt_req++;
            if (cap_first && mem_req) begin
                first_addr = mem_addr;
                cap_first = 1'b0;
            end
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    chk("R4 unexpected beat", {22'd0, out_keep, out_last, out_data}, 32'hFFFF_FFFF);
                end else begin
                    beat_t e;
                    e = exp_q.pop_front();
                    chk("R4 beat keep/last", {30'd0, out_keep, out_last}, {30'd0, e.keep, e.last});
                    if (e.keep) chk("R3 beat data", {24'd0, out_data}, {24'd0, e.data});
                end
            end
        end
    end

    task automatic push_bytes(input int addr, input int len, input bit last_end);
        for (int i = 0; i < len; i++) begin
            beat_t b;
            b.keep = 1'b1;
            b.last = last_end && (i == len - 1);
            b.data = pat(addr + i);
            exp_q.push_back(b);
        end
    endtask

    task automatic push_mark();
        beat_t b;
        b.keep = 1'b0; b.last = 1'b1; b.data = 8'h00;
        exp_q.push_back(b);
    endtask

    task automatic set_desc(input int a, input logic [15:0] fl, input logic [15:0] len,
                            input logic [31:0] bp);
        mem[a >> 2]       = {fl, len};
        mem[(a >> 2) + 1] = bp;
    endtask

    task automatic run_demand();
        @(negedge clk);
        demand = 1'b1;
        cap_first = 1'b1;
        @(negedge clk);
        demand = 1'b0;
        while (demand_busy) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic write_base(input logic [31:0] v);
        @(negedge clk);
        ring_base_wr = 1'b1;
        ring_base_data = v;
        @(negedge clk);
        ring_base_wr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int b0, f0, x0, r0;
        for (int i = 0; i < 512; i++)
            mem[i] = {pat(4*i+3), pat(4*i+2), pat(4*i+1), pat(4*i)};
        for (int i = 64; i < 128; i++) mem[i] = '0;
        for (int i = 192; i < 256; i++) mem[i] = '0;

        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12 busy after reset", {31'd0, demand_busy}, 32'd0);
        chk("R12 req/valid after reset", {30'd0, mem_req, out_valid}, 32'd0);
        rst_n = 1'b1;

        // R10: low address bits of ring start are dropped
        write_base(32'h0000_0103);
        repeat (2) @(negedge clk);
        ctrl_enable = 1'b1;

        // R3 R4 R7: two fragments, unaligned buffer, last on second
        set_desc(32'h100, 16'h8000, 16'd5, 32'h201);
        set_desc(32'h108, 16'h8800, 16'd3, 32'h20A);
        push_bytes(32'h201, 5, 0);
        push_bytes(32'h20A, 3, 1);
        b0 = cnt_buf; f0 = cnt_frame; x0 = cnt_bab;
        run_demand();
        chk("R10 first read at masked ring start", first_addr, 32'h100);
        chk("R4 all beats consumed", exp_q.size(), 0);
        chk("R7 txbuf count", cnt_buf - b0, 2);
        chk("R7 txframe count", cnt_frame - f0, 1);
        chk("R5 no babble", cnt_bab - x0, 0);
        chk("R7 writeback word0 d0", mem[32'h100 >> 2], 32'h0000_0005);
        chk("R7 writeback word0 d1", mem[32'h108 >> 2], 32'h0800_0003);
        chk("R1 busy back to zero", {31'd0, demand_busy}, 32'd0);

        // R2: stop at not-ready descriptor, pointer kept
        b0 = cnt_buf;
        run_demand();
        chk("R2 resumes at stopped descriptor", first_addr, 32'h110);
        chk("R2 no event on not-ready", cnt_buf - b0, 0);

        // R8: wrap back to ring start
        set_desc(32'h110, 16'hA800, 16'd2, 32'h230);
        push_bytes(32'h230, 2, 1);
        run_demand();
        chk("R8 wrap frame consumed", exp_q.size(), 0);
        run_demand();
        chk("R8 pointer wrapped to ring start", first_addr, 32'h100);

        // R5: babble truncation of second fragment
        set_desc(32'h100, 16'h8000, 16'd12, 32'h240);
        set_desc(32'h108, 16'h8800, 16'd15, 32'h260);
        push_bytes(32'h240, 12, 0);
        push_bytes(32'h260, 8, 1);
        x0 = cnt_bab; f0 = cnt_frame;
        run_demand();
        chk("R5 truncated frame consumed", exp_q.size(), 0);
        chk("R5 babble once", cnt_bab - x0, 1);
        chk("R5 length field kept in writeback", mem[32'h108 >> 2], 32'h0800_000F);

        // R6: last descriptor after the cap contributes zero bytes
        set_desc(32'h110, 16'h8000, 16'd25, 32'h200);
        set_desc(32'h118, 16'h8800, 16'd4, 32'h220);
        push_bytes(32'h200, 20, 0);
        push_mark();
        x0 = cnt_bab; f0 = cnt_frame;
        run_demand();
        chk("R6 keep-less last beat seen", exp_q.size(), 0);
        chk("R6 babble on both", cnt_bab - x0, 2);
        chk("R6 frame event", cnt_frame - f0, 1);

        // R9 R10: reload from new ring start, walk limit per demand
        ctrl_enable = 1'b0;
        write_base(32'h300);
        repeat (2) @(negedge clk);
        ctrl_enable = 1'b1;
        for (int i = 0; i < 8; i++) begin
            set_desc(32'h300 + 8*i, 16'h8800, 16'd1, 32'h280 + i);
            push_bytes(32'h280 + i, 1, 1);
        end
        for (int i = 0; i < 2; i++) exp_q.delete(exp_q.size() - 1);
        f0 = cnt_frame;
        run_demand();
        chk("R10 reload after disable", first_addr, 32'h300);
        chk("R9 frames per demand capped", cnt_frame - f0, WLIM);
        chk("R9 next descriptor still ready", mem[32'h330 >> 2], 32'h8800_0001);
        push_bytes(32'h286, 1, 1);
        push_bytes(32'h287, 1, 1);
        run_demand();
        chk("R9 resumes after limit", first_addr, 32'h330);
        chk("R9 remainder consumed", exp_q.size(), 0);

        // R1: demand while disabled is ignored; R10 reload observed after
        ctrl_enable = 1'b0;
        repeat (2) @(negedge clk);
        r0 = cnt_req;
        @(negedge clk); demand = 1'b1;
        @(negedge clk); demand = 1'b0;
        repeat (5) @(negedge clk);
        chk("R1 disabled demand: busy", {31'd0, demand_busy}, 32'd0);
        chk("R1 disabled demand: no request", cnt_req - r0, 0);
        ctrl_enable = 1'b1;
        run_demand();
        chk("R10 pointer reloaded while disabled", first_addr, 32'h300);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule